// File: doc/BRIEF.md
# Watermark-Request FIFO Pair

This block holds the two data queues of a serial port. One queue carries words from the host side (a CPU or DMA engine) toward the serial shifter. The other carries words from the shifter back to the host. Each queue is 16 entries deep and 32 bits wide. A host access moves exactly one whole entry, and byte enables choose which lanes carry data.

Each direction has its own 3-bit watermark code that sets a threshold. The transmit request rises when the transmit queue has enough free entries to take another burst. The receive request rises when the receive queue holds enough valid words to be worth draining. Both requests are levels that an interrupt or DMA controller can use directly.

Illegal accesses are dropped and recorded in sticky flags. A push to a full queue sets an overflow flag, and a pop from an empty queue sets an underflow flag. Each queue can be flushed on its own.

Top module: `wm_fifo_pair`

## Requirements
- R1: Each queue keeps up to 16 words of 32 bits in first-in first-out order. A host transmit push stores one whole entry. Byte-enable bit i covers data bits 8i+7:8i, and a lane whose enable is 0 is stored as zero.
- R2: The head entry of each queue is always visible on its read-data output. Each pop advances the queue by exactly one entry. On the host receive read, a lane whose enable bit in `hostRxBe` is 0 reads as zero.
- R3: A push to a full queue with no pop in the same cycle is dropped, leaves the count unchanged and sets that queue's overflow flag. A pop from an empty queue with no push in the same cycle is dropped, leaves the count unchanged and sets that queue's underflow flag.
- R4: The four flags are sticky. Each one clears only when the matching `flagClr` bit is 1 on a clock edge. The bit order is: 0 = transmit overflow, 1 = transmit underflow, 2 = receive overflow, 3 = receive underflow.
- R5: The receive request is high while the valid count is at least the selected threshold. The codes map as follows: 000 gives 1, 100 gives 4, 101 gives 8, 110 gives 12 and 111 gives 16. With code 111 the request is high only when the queue is full.
- R6: The transmit request is high while the free count (16 minus the count) is at least the selected threshold. The codes map as follows: 000 gives 16, 100 gives 12, 101 gives 8, 110 gives 4 and 111 gives 1. With code 000 the request is high only when the queue is empty. The two codes are independent.
- R7: The codes 001, 010 and 011 behave exactly like 000, in both directions.
- R8: The requests are decoded from the registered counts and the current codes. A request therefore changes in the same cycle as the count change that caused it, which is one clock edge after the push or pop.
- R9: A flush empties its queue on one clock edge. A push or pop on that queue in the same cycle is discarded, and the flags keep their values.
- R10: A push and a pop on the same queue in one cycle leave the count unchanged. This is legal when the queue is full. It is also legal when the queue is empty, in which case the pushed word appears on the read-data output in that same cycle. Neither case sets a flag.
- R11: Each count is 5 bits wide and covers 0 to 16. After reset both counts are 0, all flags are 0, the transmit request is 1 and the receive request is 0 (both codes 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txWmCode | input | 3 | Transmit watermark code |
| rxWmCode | input | 3 | Receive watermark code |
| hostTxPush | input | 1 | Host writes one entry into the transmit queue |
| hostTxData | input | 32 | Host write data |
| hostTxBe | input | 4 | Byte enables for the host write |
| hostRxPop | input | 1 | Host removes one entry from the receive queue |
| hostRxBe | input | 4 | Byte enables for the host read |
| hostRxData | output | 32 | Head of the receive queue, masked by the enables |
| serTxPop | input | 1 | Shifter removes one entry from the transmit queue |
| serTxData | output | 32 | Head of the transmit queue |
| serRxPush | input | 1 | Shifter writes one entry into the receive queue |
| serRxData | input | 32 | Shifter write data |
| txFlush | input | 1 | Empty the transmit queue |
| rxFlush | input | 1 | Empty the receive queue |
| flagClr | input | 4 | Write-one-to-clear for the sticky flags |
| txCount | output | 5 | Entries held in the transmit queue |
| rxCount | output | 5 | Entries held in the receive queue |
| txReq | output | 1 | Transmit request level |
| rxReq | output | 1 | Receive request level |
| txOvf | output | 1 | Sticky transmit overflow flag |
| txUdf | output | 1 | Sticky transmit underflow flag |
| rxOvf | output | 1 | Sticky receive overflow flag |
| rxUdf | output | 1 | Sticky receive underflow flag |

## Verification
Counts, flags and flush results are registered, so they are due one edge after the cycle in which their stimulus is applied. The requests follow the counts with no further delay. Read data, including the empty-queue pass-through, is combinational and is due in the same cycle as the stimulus. The bench drives inputs on the falling edge. It samples data outputs a moment after driving them, and samples counts, requests and flags on the next falling edge, so each result is read exactly in the cycle it is due.

// File: rtl/wmfp_pkg.sv
package wmfp_pkg;

  // Strobes sent from a queue's control to its datapath
  typedef struct packed {
    logic wrEn;    // store wrData at the write pointer and advance it
    logic rdEn;    // advance the read pointer
    logic bypass;  // queue empty with push and pop together: pass write data through
    logic clear;   // flush: both pointers return to zero
  } fifoStrobe_t;

endpackage

// File: rtl/wmfp_dpath.sv
module wmfp_dpath
  import wmfp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoStrobe_t         stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W/8-1:0] wrBe,
  input  logic [DATA_W/8-1:0] rdBe,
  output logic [DATA_W-1:0]   rdData
);
  localparam int LANES = DATA_W / 8;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] wrMask, rdMask, wrMasked, headWord;

  // expand the byte enables into bit masks
  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_mask
      assign wrMask[lane*8 +: 8] = {8{wrBe[lane]}};
      assign rdMask[lane*8 +: 8] = {8{rdBe[lane]}};
    end
  endgenerate

  assign wrMasked = wrData & wrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrEn) begin
        mem[wrPtr] <= wrMasked;
        wrPtr      <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (stb.rdEn) begin
        rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
    end
  end

  assign headWord = stb.bypass ? wrMasked : mem[rdPtr];
  assign rdData   = headWord & rdMask;

endmodule

// File: rtl/wmfp_ctrl.sv
module wmfp_ctrl
  import wmfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        push,
  input  logic                        pop,
  input  logic                        flush,
  input  logic                        clrOvf,
  input  logic                        clrUdf,
  input  logic [2:0]                  wmCode,
  output fifoStrobe_t                 stb,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        req,
  output logic                        ovf,
  output logic                        udf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] T1   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TQ1  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] TQ2  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQ3  = CNT_W'((3 * DEPTH) / 4);

  logic full, empty, doPush, doPop, ovfEv, udfEv;
  logic [CNT_W-1:0] thresh, metric;

  assign full  = (count == FULL);
  assign empty = (count == '0);

  // with both strobes the illegal one completes second, so it stays legal
  assign doPush = push && (!full  || pop);
  assign doPop  = pop  && (!empty || push);
  assign ovfEv  = !flush && push && full  && !pop;
  assign udfEv  = !flush && pop  && empty && !push;

  always_comb begin
    stb        = '0;
    stb.clear  = flush;
    stb.wrEn   = doPush && !flush;
    stb.rdEn   = doPop  && !flush;
    stb.bypass = empty && push && pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      if (flush)                count <= '0;
      else if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
      ovf <= (ovf && !clrOvf) || ovfEv;
      udf <= (udf && !clrUdf) || udfEv;
    end
  end

  // threshold decode: transmit measures free room, receive measures fill
  always_comb begin
    unique case (wmCode)
      3'b100:  thresh = IS_TX ? TQ3 : TQ1;
      3'b101:  thresh = TQ2;
      3'b110:  thresh = IS_TX ? TQ1 : TQ3;
      3'b111:  thresh = IS_TX ? T1  : FULL;
      default: thresh = IS_TX ? FULL : T1;   // 000 and reserved codes
    endcase
  end

  assign metric = IS_TX ? (FULL - count) : count;
  assign req    = (metric >= thresh);

endmodule

// File: rtl/wm_fifo_pair.sv
module wm_fifo_pair
  import wmfp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        txWmCode,
  input  logic [2:0]        rxWmCode,
  input  logic              hostTxPush,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic [BE_W-1:0]   hostTxBe,
  input  logic              hostRxPop,
  input  logic [BE_W-1:0]   hostRxBe,
  output logic [DATA_W-1:0] hostRxData,
  input  logic              serTxPop,
  output logic [DATA_W-1:0] serTxData,
  input  logic              serRxPush,
  input  logic [DATA_W-1:0] serRxData,
  input  logic              txFlush,
  input  logic              rxFlush,
  input  logic [3:0]        flagClr,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txReq,
  output logic              rxReq,
  output logic              txOvf,
  output logic              txUdf,
  output logic              rxOvf,
  output logic              rxUdf
);
  // index 0 = transmit direction, index 1 = receive direction
  logic              pushV  [2];
  logic              popV   [2];
  logic              flushV [2];
  logic [2:0]        wmV    [2];
  logic [DATA_W-1:0] wrDataV[2];
  logic [BE_W-1:0]   wrBeV  [2];
  logic [BE_W-1:0]   rdBeV  [2];
  logic [DATA_W-1:0] rdDataV[2];
  logic [CNT_W-1:0]  cntV   [2];
  logic              reqV   [2];
  logic              ovfV   [2];
  logic              udfV   [2];

  assign pushV[0]   = hostTxPush;  assign pushV[1]   = serRxPush;
  assign popV[0]    = serTxPop;    assign popV[1]    = hostRxPop;
  assign flushV[0]  = txFlush;     assign flushV[1]  = rxFlush;
  assign wmV[0]     = txWmCode;    assign wmV[1]     = rxWmCode;
  assign wrDataV[0] = hostTxData;  assign wrDataV[1] = serRxData;
  assign wrBeV[0]   = hostTxBe;    assign wrBeV[1]   = '1;
  assign rdBeV[0]   = '1;          assign rdBeV[1]   = hostRxBe;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_dir
      fifoStrobe_t stb;

      wmfp_ctrl #(.DEPTH(DEPTH), .IS_TX(g == 0)) u_ctrl (
        .clk    (clk),
        .rstN   (rstN),
        .push   (pushV[g]),
        .pop    (popV[g]),
        .flush  (flushV[g]),
        .clrOvf (flagClr[2*g]),
        .clrUdf (flagClr[2*g+1]),
        .wmCode (wmV[g]),
        .stb    (stb),
        .count  (cntV[g]),
        .req    (reqV[g]),
        .ovf    (ovfV[g]),
        .udf    (udfV[g])
      );

      wmfp_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
        .clk    (clk),
        .rstN   (rstN),
        .stb    (stb),
        .wrData (wrDataV[g]),
        .wrBe   (wrBeV[g]),
        .rdBe   (rdBeV[g]),
        .rdData (rdDataV[g])
      );
    end
  endgenerate

  assign serTxData  = rdDataV[0];
  assign hostRxData = rdDataV[1];
  assign txCount    = cntV[0];
  assign rxCount    = cntV[1];
  assign txReq      = reqV[0];
  assign rxReq      = reqV[1];
  assign txOvf      = ovfV[0];
  assign txUdf      = udfV[0];
  assign rxOvf      = ovfV[1];
  assign rxUdf      = udfV[1];

endmodule

// File: rtl/wmfp_checker.sv
module wmfp_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        txWmCode,
  input logic [2:0]        rxWmCode,
  input logic              hostTxPush,
  input logic              hostRxPop,
  input logic              serTxPop,
  input logic              serRxPush,
  input logic              txFlush,
  input logic              rxFlush,
  input logic [3:0]        flagClr,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              txReq,
  input logic              rxReq,
  input logic              txOvf,
  input logic              txUdf,
  input logic              rxOvf,
  input logic              rxUdf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= FULL && rxCount <= FULL);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostTxPush && !serTxPop && !txFlush && txCount == FULL |=> txOvf && txCount == FULL);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostRxPop && !serRxPush && !rxFlush && rxCount == '0 |=> rxUdf && rxCount == '0);

  assert_sticky_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxOvf && !flagClr[2] |=> rxOvf);

  assert_rx_full_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxWmCode == 3'b111 && rxReq |-> rxCount == FULL);

  assert_tx_empty_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    txWmCode == 3'b000 && txReq |-> txCount == '0);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> txCount == '0);

  assert_push_pop_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    serRxPush && hostRxPop && !rxFlush |=> $stable(rxCount) && !$rose(rxOvf) && !$rose(rxUdf));

endmodule

bind wm_fifo_pair wmfp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/wm_fifo_pair_tb.sv
module wm_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  txWmCode, rxWmCode;
  logic        hostTxPush, hostRxPop, serTxPop, serRxPush, txFlush, rxFlush;
  logic [31:0] hostTxData, serRxData, hostRxData, serTxData;
  logic [3:0]  hostTxBe, hostRxBe, flagClr;
  logic [4:0]  txCount, rxCount;
  logic        txReq, rxReq, txOvf, txUdf, rxOvf, rxUdf;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;   // 125 MHz

  wm_fifo_pair u_dut (.*);

  typedef struct packed {
    logic       txPush;
    logic       rxPush;
    logic       txPop;
    logic       rxPop;
    logic [2:0] txWm;
    logic [2:0] rxWm;
    logic [4:0] expTx;
    logic [4:0] expRx;
    logic       expTxReq;
    logic       expRxReq;
  } vec_t;

  // one row per cycle, starting with both queues empty
  localparam vec_t VECS [9] = '{
    '{1'b0,1'b0,1'b0,1'b0, 3'b000,3'b000, 5'd0,5'd0, 1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b0, 3'b000,3'b000, 5'd1,5'd1, 1'b0,1'b1},
    '{1'b1,1'b1,1'b0,1'b0, 3'b111,3'b100, 5'd2,5'd2, 1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b0, 3'b110,3'b100, 5'd3,5'd3, 1'b1,1'b0},
    '{1'b1,1'b1,1'b0,1'b0, 3'b110,3'b100, 5'd4,5'd4, 1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b1, 3'b100,3'b101, 5'd4,5'd4, 1'b1,1'b0},  // push+pop, R10
    '{1'b0,1'b0,1'b1,1'b1, 3'b100,3'b001, 5'd3,5'd3, 1'b1,1'b1},  // reserved rx code, R7
    '{1'b0,1'b0,1'b0,1'b0, 3'b011,3'b110, 5'd3,5'd3, 1'b0,1'b0},  // reserved tx code, R7
    '{1'b0,1'b0,1'b1,1'b0, 3'b101,3'b111, 5'd2,5'd3, 1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    hostTxPush = 0; hostRxPop = 0; serTxPop = 0; serRxPush = 0;
    txFlush = 0; rxFlush = 0; flagClr = 4'b0;
    hostTxBe = 4'hF; hostRxBe = 4'hF;
  endtask

  // apply current inputs for one edge, return at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] word(input int i);
    return {4{8'(8'h10 + i)}};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    txWmCode = 3'b000; rxWmCode = 3'b000;
    hostTxData = '0; serRxData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 txCount", 32'(txCount), 0);
    chk("R11 rxCount", 32'(rxCount), 0);
    chk("R11 flags", {28'b0, rxUdf, rxOvf, txUdf, txOvf}, 0);
    chk("R11 txReq", 32'(txReq), 1);
    chk("R11 rxReq", 32'(rxReq), 0);

    // table walk: counts and request levels, one edge per row
    for (int i = 0; i < 9; i++) begin
      txWmCode   = VECS[i].txWm;
      rxWmCode   = VECS[i].rxWm;
      hostTxPush = VECS[i].txPush;
      serRxPush  = VECS[i].rxPush;
      serTxPop   = VECS[i].txPop;
      hostRxPop  = VECS[i].rxPop;
      hostTxData = 32'hA000_0000 + i;
      serRxData  = 32'hB000_0000 + i;
      step();
      chk("R11 txCount", 32'(txCount), 32'(VECS[i].expTx));
      chk("R11 rxCount", 32'(rxCount), 32'(VECS[i].expRx));
      chk("R6/R8 txReq", 32'(txReq), 32'(VECS[i].expTxReq));
      chk("R5/R8 rxReq", 32'(rxReq), 32'(VECS[i].expRxReq));
    end

    // R9 flush both queues, together with a push that must be discarded
    txFlush = 1; rxFlush = 1; hostTxPush = 1; serRxPush = 1;
    step();
    chk("R9 txCount", 32'(txCount), 0);
    chk("R9 rxCount", 32'(rxCount), 0);

    // fill the receive queue, code 111 needs a full queue (R5)
    rxWmCode = 3'b111;
    for (int i = 0; i < 16; i++) begin
      serRxPush = 1; serRxData = word(i);
      step();
      if (i == 14) chk("R5 rxReq at 15", 32'(rxReq), 0);
    end
    chk("R5 rxReq full", 32'(rxReq), 1);
    chk("R11 rxCount full", 32'(rxCount), 16);

    // R3 push to full is dropped
    serRxPush = 1; serRxData = 32'hDEAD_BEEF;
    step();
    chk("R3 rxCount", 32'(rxCount), 16);
    chk("R3 rxOvf", 32'(rxOvf), 1);
    step();
    chk("R4 rxOvf sticky", 32'(rxOvf), 1);
    flagClr = 4'b0100;
    step();
    chk("R4 rxOvf cleared", 32'(rxOvf), 0);

    // R10 push and pop together on a full queue
    serRxPush = 1; serRxData = word(16); hostRxPop = 1;
    #1 chk("R2 head word", hostRxData, word(0));
    step();
    chk("R10 rxCount full", 32'(rxCount), 16);
    chk("R10 no rxOvf", 32'(rxOvf), 0);

    // R2 byte-lane masking on the host read
    hostRxPop = 1; hostRxBe = 4'b0101;
    #1 chk("R2 masked read", hostRxData, word(1) & 32'h00FF_00FF);
    step();
    for (int i = 2; i <= 16; i++) begin
      hostRxPop = 1;
      #1 chk("R2 order", hostRxData, word(i));
      step();
    end
    chk("R11 rxCount empty", 32'(rxCount), 0);

    // R3 pop from empty
    hostRxPop = 1;
    step();
    chk("R3 rxUdf", 32'(rxUdf), 1);
    chk("R3 rxCount", 32'(rxCount), 0);
    flagClr = 4'b1000;
    step();
    chk("R4 rxUdf cleared", 32'(rxUdf), 0);

    // R10 push and pop together on an empty queue: pass-through
    serRxPush = 1; serRxData = 32'h5A5A_1234; hostRxPop = 1;
    #1 chk("R10 pass-through", hostRxData, 32'h5A5A_1234);
    step();
    chk("R10 rxCount empty", 32'(rxCount), 0);
    chk("R10 no rxUdf", 32'(rxUdf), 0);

    // R1 write lane masking on the transmit side
    txWmCode = 3'b000;
    hostTxPush = 1; hostTxData = 32'hAABB_CCDD; hostTxBe = 4'b1100;
    step();
    chk("R1 stored lanes", serTxData, 32'hAABB_0000);
    chk("R6 txReq not empty", 32'(txReq), 0);
    serTxPop = 1;
    step();
    chk("R6 txReq empty", 32'(txReq), 1);
    serTxPop = 1;
    step();
    chk("R3 txUdf", 32'(txUdf), 1);

    // fill transmit queue, overflow, code 111 at full
    txWmCode = 3'b111;
    for (int i = 0; i < 17; i++) begin
      hostTxPush = 1; hostTxData = word(i);
      step();
    end
    chk("R3 txCount", 32'(txCount), 16);
    chk("R3 txOvf", 32'(txOvf), 1);
    chk("R6 txReq full", 32'(txReq), 0);
    chk("R1 first word", serTxData, word(0));

    // R9 flush keeps flags
    txFlush = 1;
    step();
    chk("R9 txCount", 32'(txCount), 0);
    chk("R9 flags kept", {30'b0, txUdf, txOvf}, 32'b11);
    chk("R6 txReq after flush", 32'(txReq), 1);
    flagClr = 4'b0011;
    step();
    chk("R4 tx flags cleared", {30'b0, txUdf, txOvf}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule